// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the command side of a serial byte-addressed memory. It behaves as an SPI target in mode 0: a host lowers chip select, clocks an 8-bit opcode in on SI, and then sends an address or data, or clocks data out on SO. The engine reads from and writes into a byte array of 2^ADDR_W registers that it holds itself. Write permission comes from a separate protection block. This engine tells that block when the write-enable latch should be set or cleared. It reads back the latch state, the permits for the array and for the status byte, and the upper status bits.

Reads stream out without limit from a 16-bit start address and wrap over the whole array. Writes are gathered into a one-page buffer that wraps inside its page. The buffer is written into the array only when chip select rises cleanly after at least one whole data byte. After that the engine stays busy for a fixed number of clock cycles and clears the latch when that period ends. SCK, SI and chip select are sampled by the system clock `clk`. They must be synchronous to it, and each SCK phase must last at least two `clk` cycles. High impedance on SO is represented by `so_en` being low. BUSY_CYCLES must be at least 2^PAGE_W, so that the whole page is written back inside the busy window.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset, `so_en` is 0, busy is 0, and a status read returns 8'h00 when the protection block reports all-zero status bits.
- R2: Opcode 8'h06 produces a one-cycle `wel_set` pulse and opcode 8'h04 produces a one-cycle `wel_clr` pulse. Both take effect only when the engine is not busy.
- R3: Opcode 8'h03 is followed by a 16-bit address, sent MSB first, of which only the low ADDR_W bits are used. The byte at that address is then shifted out MSB first on SO. SI is sampled on SCK rising edges and SO changes after SCK falling edges.
- R4: While clocks continue, a read moves on to the next address after each byte, and from the highest address 2^ADDR_W-1 it continues at address 0.
- R5: Opcode 8'h02 (page write) and opcode 8'h01 (status write) are ignored, leaving the array and status unchanged, when `wel` is 0 at the time the opcode byte completes.
- R6: During a page write, each data byte goes to the current address. Only the low PAGE_W address bits then advance, wrapping inside the page, so later bytes overwrite earlier ones at the same offset.
- R7: Buffered page data reaches the array only if chip select rises when the bit count is a multiple of 8, at least one data byte has been received, and `prot_arr_ok` is 1. Otherwise the data is discarded and busy does not start.
- R8: Opcode 8'h05 returns {prot_status[6:0], busy}, with busy in bit 0. The value is refreshed for every byte while clocks continue, and this opcode is accepted even while busy.
- R9: A committed page write or status write holds busy for exactly BUSY_CYCLES clock cycles. In the last of those cycles `wel_clr` pulses.
- R10: While busy, every opcode other than 8'h05 is ignored: no latch pulse is produced and SO is not driven.
- R11: An enabled status write commits its last complete data byte under the same boundary rule as R7 and only if `prot_sr_ok` is 1. The commit produces a one-cycle `sr_wr_stb` with that byte on `sr_wr_data` and then starts busy.
- R12: `so_en` is 0 whenever `cs_n` is high and during opcode and address phases. It is 1 only while read data or status is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | SO drive enable; 0 means high impedance |
| wel | input | 1 | Write-enable latch state from the protection block |
| prot_status | input | 7 | Status bits 7..1 supplied by the protection block |
| prot_arr_ok | input | 1 | Permit to commit to the page at `prot_addr` |
| prot_sr_ok | input | 1 | Permit to commit a status write |
| prot_addr | output | ADDR_W | Current write address, for the protection check |
| wel_set | output | 1 | Request to set the write-enable latch |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| sr_wr_stb | output | 1 | Status byte commit strobe |
| sr_wr_data | output | 8 | Status byte to be committed |

## Verification
The assertions check on every cycle that SO is never driven while deselected and that busy only starts right after a chip-select rise. They also check that busy lasts exactly BUSY_CYCLES with a latch-clear pulse at its end, that no set pulse and no array write occur outside the rules, and that the page number stays fixed while data bytes arrive. Only the bench scenarios can show that the bytes which come out are the right ones. That covers the wrap at the top of the array and inside a page, the upper address bits being ignored, and commits being dropped on a partial byte, an empty write or a refused permit. It also covers status bytes seen during and after a busy period.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    ST_OPC,   // collecting opcode
    ST_AHI,   // address high byte
    ST_ALO,   // address low byte
    ST_RDAT,  // streaming array data out
    ST_WDAT,  // collecting page data
    ST_SRD,   // streaming status out
    ST_SWR,   // collecting status byte
    ST_IGN    // rest of frame ignored
  } eng_state_t;

  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

endpackage

// File: rtl/spi_mem_edges.sv
module spi_mem_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck && !sck_q;
  assign sck_fall = !sck && sck_q;
  assign cs_rise  = cs_n && !cs_q;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/spi_mem_commit.sv
module spi_mem_commit #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 6,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 800
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     fill_en,
  input  logic [PAGE_W-1:0]        fill_idx,
  input  logic [DATA_W-1:0]        fill_data,
  input  logic                     start_arr,
  input  logic                     start_sr,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic                     busy,
  output logic                     cycle_end,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [DATA_W-1:0]        mem_wdata
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [DATA_W-1:0]        pbuf_q [PAGE];
  logic [PAGE-1:0]          vld_q;
  logic                     busy_q;
  logic                     arr_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [PAGE_W:0]          idx_q;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic                     start;

  assign start = start_arr || start_sr;

  // Page staging buffer with one valid flag per offset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < PAGE; i++) pbuf_q[i] <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (fill_en) begin
      pbuf_q[fill_idx] <= fill_data;
      vld_q[fill_idx]  <= 1'b1;
    end
  end

  // Busy timer and write-back sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      arr_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      arr_q  <= start_arr;
      cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
      idx_q  <= '0;
      base_q <= page_base;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (!idx_q[PAGE_W]) idx_q <= idx_q + 1'b1;
    end
  end

  assign busy      = busy_q;
  assign cycle_end = busy_q && (cnt_q == '0);
  assign mem_we    = busy_q && arr_q && !idx_q[PAGE_W] && vld_q[idx_q[PAGE_W-1:0]];
  assign mem_waddr = {base_q, idx_q[PAGE_W-1:0]};
  assign mem_wdata = pbuf_q[idx_q[PAGE_W-1:0]];
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYCLES = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_en,
  input  logic              wel,
  input  logic [6:0]        prot_status,
  input  logic              prot_arr_ok,
  input  logic              prot_sr_ok,
  output logic [ADDR_W-1:0] prot_addr,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              sr_wr_stb,
  output logic [7:0]        sr_wr_data
);
  localparam int HI_W = ADDR_W - 8;

  // Address arithmetic: full-array wrap for reads, in-page wrap for writes.
  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  // Named internal events
  logic sck_rise, sck_fall, cs_rise;
  logic sel, byte_done, boundary;
  logic fill_en, buf_clr, commit_arr, commit_sr;
  logic busy, cycle_end, mem_we;

  eng_state_t        st_q;
  logic [2:0]        bit_q;
  logic [6:0]        sh_q;
  logic [HI_W-1:0]   ah_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              got_q;
  logic [7:0]        out_q;
  logic              so_q, so_on_q;
  logic [7:0]        sr_q;
  logic              wel_set_q, wrdi_q, sr_stb_q;

  logic [7:0]        rx_byte;
  logic [ADDR_W-1:0] addr_new;
  logic [ADDR_W-1:0] raddr;
  logic [7:0]        mem_rdata;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [7:0]        status_byte;

  spi_mem_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise)
  );

  assign sel         = !cs_n;
  assign byte_done   = sck_rise && sel && (bit_q == 3'd7);
  assign boundary    = (bit_q == 3'd0);
  assign rx_byte     = {sh_q, si};
  assign addr_new    = {ah_q, rx_byte};
  assign status_byte = {prot_status, busy};
  assign raddr       = (st_q == ST_ALO) ? addr_new : seq_next(addr_q);

  assign fill_en    = byte_done && (st_q == ST_WDAT);
  assign buf_clr    = byte_done && (st_q == ST_ALO) && !rd_q;
  assign commit_arr = cs_rise && (st_q == ST_WDAT) && got_q && boundary && prot_arr_ok;
  assign commit_sr  = cs_rise && (st_q == ST_SWR)  && got_q && boundary && prot_sr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OPC;
      bit_q     <= '0;
      sh_q      <= '0;
      ah_q      <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      got_q     <= 1'b0;
      out_q     <= '0;
      so_q      <= 1'b0;
      so_on_q   <= 1'b0;
      sr_q      <= '0;
      wel_set_q <= 1'b0;
      wrdi_q    <= 1'b0;
      sr_stb_q  <= 1'b0;
    end else begin
      wel_set_q <= 1'b0;
      wrdi_q    <= 1'b0;
      sr_stb_q  <= commit_sr;
      if (!sel) begin
        st_q    <= ST_OPC;
        bit_q   <= '0;
        so_on_q <= 1'b0;
        got_q   <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= rx_byte[6:0];
        end
        if (sck_fall && (st_q == ST_RDAT || st_q == ST_SRD)) begin
          so_q    <= out_q[7];
          out_q   <= {out_q[6:0], 1'b0};
          so_on_q <= 1'b1;
        end
        if (byte_done) begin
          case (st_q)
            ST_OPC: begin
              if (rx_byte == OPC_RDSR) begin
                st_q  <= ST_SRD;
                out_q <= status_byte;
              end else if (busy) begin
                st_q <= ST_IGN;
              end else begin
                case (rx_byte)
                  OPC_READ: begin
                    st_q <= ST_AHI;
                    rd_q <= 1'b1;
                  end
                  OPC_WRITE: begin
                    st_q <= wel ? ST_AHI : ST_IGN;
                    rd_q <= 1'b0;
                  end
                  OPC_WRSR: st_q <= wel ? ST_SWR : ST_IGN;
                  OPC_WREN: begin
                    wel_set_q <= 1'b1;
                    st_q      <= ST_IGN;
                  end
                  OPC_WRDI: begin
                    wrdi_q <= 1'b1;
                    st_q   <= ST_IGN;
                  end
                  default: st_q <= ST_IGN;
                endcase
              end
            end
            ST_AHI: begin
              ah_q <= rx_byte[HI_W-1:0];
              st_q <= ST_ALO;
            end
            ST_ALO: begin
              addr_q <= addr_new;
              got_q  <= 1'b0;
              if (rd_q) begin
                st_q  <= ST_RDAT;
                out_q <= mem_rdata;
              end else begin
                st_q <= ST_WDAT;
              end
            end
            ST_RDAT: begin
              addr_q <= seq_next(addr_q);
              out_q  <= mem_rdata;
            end
            ST_WDAT: begin
              addr_q <= page_next(addr_q);
              got_q  <= 1'b1;
            end
            ST_SRD: out_q <= status_byte;
            ST_SWR: begin
              sr_q  <= rx_byte;
              got_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  spi_mem_commit #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .DATA_W      (8),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (buf_clr),
    .fill_en   (fill_en),
    .fill_idx  (addr_q[PAGE_W-1:0]),
    .fill_data (rx_byte),
    .start_arr (commit_arr),
    .start_sr  (commit_sr),
    .page_base (addr_q[ADDR_W-1:PAGE_W]),
    .busy      (busy),
    .cycle_end (cycle_end),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  spi_mem_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (8)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (raddr),
    .rdata (mem_rdata)
  );

  assign so         = so_q;
  assign so_en      = sel && so_on_q;
  assign prot_addr  = addr_q;
  assign wel_set    = wel_set_q;
  assign wel_clr    = wrdi_q || cycle_end;
  assign sr_wr_stb  = sr_stb_q;
  assign sr_wr_data = sr_q;
endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYCLES = 800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              so_en,
  input logic              busy,
  input logic              cs_rise,
  input logic              wel_set,
  input logic              wel_clr,
  input logic              sr_wr_stb,
  input logic              mem_we,
  input logic              fill_en,
  input logic [ADDR_W-1:0] addr_q
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 32'd1;
    else           busy_cnt <= '0;
  end

  assert_deselect_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_en);

  assert_busy_after_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 32'(BUSY_CYCLES)));

  assert_wel_clear_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wel_clr));

  assert_no_set_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wel_set);

  assert_array_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_page_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));

  assert_sr_strobe_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_stb |-> busy);
endmodule

bind spi_mem_engine spi_mem_engine_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_W      (PAGE_W),
  .BUSY_CYCLES (BUSY_CYCLES)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .so_en     (so_en),
  .busy      (busy),
  .cs_rise   (cs_rise),
  .wel_set   (wel_set),
  .wel_clr   (wel_clr),
  .sr_wr_stb (sr_wr_stb),
  .mem_we    (mem_we),
  .fill_en   (fill_en),
  .addr_q    (addr_q)
);

// File: tb/test_spi_mem_engine.sv
`timescale 1ns/1ps
module test_spi_mem_engine;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 6;
  localparam int BUSY   = 800;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int HALF   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_en;
  logic wel_m = 1'b0;
  logic prot_arr_ok = 1'b1, prot_sr_ok = 1'b1;
  logic [ADDR_W-1:0] prot_addr;
  logic wel_set, wel_clr, sr_wr_stb;
  logic [7:0] sr_wr_data;

  always #2.5 clk = ~clk;

  spi_mem_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY)) i_spi_mem_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_en(so_en),
    .wel(wel_m), .prot_status({6'b0, wel_m}), .prot_arr_ok(prot_arr_ok),
    .prot_sr_ok(prot_sr_ok), .prot_addr(prot_addr), .wel_set(wel_set), .wel_clr(wel_clr),
    .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data)
  );

  // Stand-in for the protection block's latch
  always @(posedge clk) begin
    if (!rst_n)       wel_m <= 1'b0;
    else if (wel_set) wel_m <= 1'b1;
    else if (wel_clr) wel_m <= 1'b0;
  end

  int stb_n = 0;
  logic [7:0] stb_data = 8'h00;
  always @(posedge clk) if (rst_n && sr_wr_stb) begin
    stb_n++;
    stb_data = sr_wr_data;
  end

  int nchk = 0, nerr = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs captured bytes with expected ones
  always @(negedge clk) begin
    if (rx_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = rx_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic bit_x(input logic b, output logic r, output logic oe);
    @(negedge clk); si = b;
    repeat (HALF) @(negedge clk);
    r = so; oe = so_en;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    logic r, oe;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, oe);
      rx[i] = r;
      oe_all &= oe; oe_any |= oe;
    end
  endtask

  task automatic tx(input logic [7:0] b);
    logic [7:0] d; logic a, y;
    xfer(b, d, a, y);
  endtask

  task automatic cs_start();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_start(); tx(op); cs_end();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic a, y;
    cs_start(); tx(8'h05); xfer(8'h00, s, a, y); cs_end();
  endtask

  // Driver: issues a read and pushes the expected bytes for the monitor
  task automatic rd_stream(input logic [15:0] addr, input int n, input string tag);
    logic [7:0] d; logic a, y, hdr_oe;
    hdr_oe = 1'b0;
    cs_start();
    xfer(8'h03, d, a, y); hdr_oe |= y;
    xfer(addr[15:8], d, a, y); hdr_oe |= y;
    xfer(addr[7:0], d, a, y); hdr_oe |= y;
    check(!hdr_oe, "R12 so_en low in header", hdr_oe, 0);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[(int'(addr) + k) % DEPTH]);
      tag_q.push_back(tag);
      xfer(8'h00, d, a, y);
      check(a, "R12 so_en high in data", a, 1);
      rx_q.push_back(d);
    end
    cs_end();
    check(!so_en, "R12 so_en low after deselect", so_en, 0);
  endtask

  task automatic wr_page(input logic [15:0] addr, input int n, input logic [7:0] seed,
                         input logic [7:0] step, input bit upd);
    int a, idx;
    cs_start(); tx(8'h02); tx(addr[15:8]); tx(addr[7:0]);
    for (int k = 0; k < n; k++) tx(seed + 8'(k) * step);
    cs_end();
    if (upd) begin
      a = int'(addr) % DEPTH;
      for (int k = 0; k < n; k++) begin
        idx = (a / PAGE) * PAGE + ((a % PAGE) + k) % PAGE;
        model[idx] = seed + 8'(k) * step;
      end
    end
  endtask

  task automatic wait_ready();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] s, d, d2;
    logic a, y;
    int n0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(!so_en, "R1 so_en after reset", so_en, 0);
    rdsr(s);
    check(s == 8'h00, "R1 R8 status after reset", s, 8'h00);

    // R5 writes without the latch are ignored
    wr_page(16'h0010, 1, 8'hAA, 8'h00, 1'b0);
    rdsr(s);
    check(s == 8'h00, "R5 no busy without latch", s, 8'h00);
    rd_stream(16'h0010, 1, "R5 array unchanged");
    cs_start(); tx(8'h01); tx(8'h8C); cs_end();
    check(stb_n == 0, "R5 R11 status write without latch", stb_n, 0);

    // R2 set and clear the latch
    cmd(8'h06);
    rdsr(s);
    check(s == 8'h02, "R2 latch set", s, 8'h02);
    cmd(8'h04);
    rdsr(s);
    check(s == 8'h00, "R2 latch cleared", s, 8'h00);

    // R6 page write across the page end, R9 busy, R10 ignore while busy
    cmd(8'h06);
    wr_page(16'h003E, 4, 8'h11, 8'h11, 1'b1);
    rdsr(s);
    check(s == 8'h03, "R9 busy after commit", s, 8'h03);
    cmd(8'h04);
    rdsr(s);
    check(s == 8'h03, "R10 clear ignored while busy", s, 8'h03);
    cs_start(); tx(8'h03); tx(8'h00); tx(8'h00); xfer(8'h00, d, a, y); cs_end();
    check(!y, "R10 read ignored while busy", y, 0);
    wait_ready();
    rdsr(s);
    check(s == 8'h00, "R9 ready and latch cleared", s, 8'h00);
    rd_stream(16'h0000, 2, "R6 wrapped bytes at page start");
    rd_stream(16'h003E, 2, "R3 R6 bytes at page end");

    // R3 upper address bits ignored
    rd_stream(16'hFC3E, 1, "R3 upper address bits ignored");

    // R4 full array wrap
    cmd(8'h06);
    wr_page(16'h03FE, 2, 8'h5C, 8'h01, 1'b1);
    wait_ready();
    rd_stream(16'h03FE, 4, "R4 read wraps to zero");

    // R6 overflow overwrites the same page
    cmd(8'h06);
    wr_page(16'h0100, PAGE + 2, 8'h01, 8'h01, 1'b1);
    wait_ready();
    rd_stream(16'h0100, 3, "R6 overflow overwrite");
    rd_stream(16'h013F, 2, "R6 page tail and next page");

    // R7 partial byte discards
    cmd(8'h06);
    cs_start(); tx(8'h02); tx(8'h02); tx(8'h00); tx(8'h5A);
    for (int k = 0; k < 3; k++) bit_x(1'b1, a, y);
    cs_end();
    rdsr(s);
    check(s == 8'h02, "R7 partial byte no commit", s, 8'h02);
    rd_stream(16'h0200, 1, "R7 partial byte array unchanged");
    // R7 no data byte
    cs_start(); tx(8'h02); tx(8'h02); tx(8'h00); cs_end();
    rdsr(s);
    check(s == 8'h02, "R7 empty write no commit", s, 8'h02);
    // R7 permit refused
    prot_arr_ok = 1'b0;
    wr_page(16'h0300, 1, 8'h77, 8'h00, 1'b0);
    rdsr(s);
    check(s == 8'h02, "R7 refused permit no commit", s, 8'h02);
    prot_arr_ok = 1'b1;
    rd_stream(16'h0300, 1, "R7 refused permit array unchanged");

    // R11 status write commit and refusal
    cs_start(); tx(8'h01); tx(8'h8C); cs_end();
    check(stb_n == 1, "R11 strobe count", stb_n, 1);
    check(stb_data == 8'h8C, "R11 strobe data", stb_data, 8'h8C);
    // R8 repeated status bytes while busy
    cs_start(); tx(8'h05); xfer(8'h00, d, a, y); xfer(8'h00, d2, a, y); cs_end();
    check(d == 8'h03, "R8 R9 status during status write", d, 8'h03);
    check(d2 == 8'h03, "R8 repeated status byte", d2, 8'h03);
    wait_ready();
    rdsr(s);
    check(s == 8'h00, "R9 latch cleared after status write", s, 8'h00);
    cmd(8'h06);
    prot_sr_ok = 1'b0;
    n0 = stb_n;
    cs_start(); tx(8'h01); tx(8'h33); cs_end();
    check(stb_n == n0, "R11 refused status write", stb_n, n0);
    rdsr(s);
    check(s == 8'h02, "R11 refused status write not busy", s, 8'h02);
    prot_sr_ok = 1'b1;
    cmd(8'h04);

    drain();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule